// File: doc/BRIEF.md
# Counter-Addressed Byte Buffer

This block is a synchronous byte-wide storage array. It takes no external addresses. A write pointer and a read pointer inside the block supply every address. A pointer steps after each access, counting up or down as configured. A pointer can also be loaded in one cycle, either from a reload value or from a fixed start value. A reload on the read side reads the byte at the loaded address in the same cycle.

Several of these blocks can share one data bus to build a deeper buffer. The top bits of each pointer form a bank number. A block only stores a byte when the write pointer's bank matches its own bank ID. It only claims the output bus when the byte it last read came from its own bank. The output is registered and carries a valid pulse and a drive-enable. Two sticky wrap flags report when a pointer steps down to zero. All configuration arrives as plain parallel inputs.

Top module: `seqbuf_mem`

## Requirements
- R1: A cycle with `wr_en` high and `wr_load` low stores `din` at the write pointer's address. The write pointer then steps. With both `wr_en` and `wr_load` low, the write pointer holds.
- R2: A cycle with `rd_en` high loads `dout` with the byte at the read pointer's address, and the read pointer then steps. A read and a write to the same address in the same cycle return the byte stored before the write. With `rd_en` and `rd_load` both low, `dout` holds.
- R3: With `cfg_count_down` = 0, a step adds one to the pointer. With `cfg_count_down` = 1, a step subtracts one. Both wrap modulo 2^ADDR_W. The setting applies to both pointers.
- R4: With `wr_load` high, the write pointer loads `wr_reload_val` when `cfg_wr_clear` = 0. When `cfg_wr_clear` = 1 it loads the start value instead: 0 when counting up, all ones when counting down. `wr_load` takes priority over `wr_en`, and nothing is stored in that cycle.
- R5: With `rd_load` high, the read pointer loads `rd_reload_val` or the start value, selected by `cfg_rd_clear` in the same way as R4. The byte at the loaded address goes to `dout`, and the pointer then steps. `rd_load` takes priority over `rd_en`.
- R6: A write is dropped, and the array left unchanged, when the top three bits of the write pointer differ from `cfg_bank_id`. The pointer still steps.
- R7: `dout_drive` is low whenever the top three bits of the address of the most recent read differ from `cfg_bank_id` as it was at that read.
- R8: `oe_n` is active low. With `cfg_oe_async` = 1 it gates `dout_drive` directly. With `cfg_oe_async` = 0, `dout_drive` follows the value of `oe_n` sampled at the last rising edge.
- R9: `wr_wrap` (or `rd_wrap`) goes high after an edge on which its pointer steps down to zero, and stays high until cleared. Stepping up, or loading zero, never sets it.
- R10: A low `wr_flag_clr_n` (or `rd_flag_clr_n`) sampled on an edge clears its flag. A clear wins over a wrap in the same cycle.
- R11: `dout_valid` is high for exactly the cycle after an edge on which `rd_en` or `rd_load` was high.
- R12: While `rst_n` is low, both pointers are zero and `dout`, `dout_valid`, `dout_drive`, `wr_wrap` and `rd_wrap` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_count_down | input | 1 | Step direction: 0 up, 1 down |
| cfg_wr_clear | input | 1 | Write load source: 1 start value, 0 reload value |
| cfg_rd_clear | input | 1 | Read load source: 1 start value, 0 reload value |
| cfg_oe_async | input | 1 | 1: `oe_n` acts directly; 0: `oe_n` is registered |
| cfg_bank_id | input | 3 | Bank number of this block |
| wr_reload_val | input | ADDR_W | Write pointer reload value |
| rd_reload_val | input | ADDR_W | Read pointer reload value |
| wr_en | input | 1 | Write and step |
| rd_en | input | 1 | Read and step |
| wr_load | input | 1 | Load write pointer |
| rd_load | input | 1 | Load read pointer and read |
| oe_n | input | 1 | Output enable, active low |
| din | input | DATA_W | Write data |
| wr_flag_clr_n | input | 1 | Clear write wrap flag, active low |
| rd_flag_clr_n | input | 1 | Clear read wrap flag, active low |
| dout | output | DATA_W | Registered read data |
| dout_valid | output | 1 | Read data updated on last edge |
| dout_drive | output | 1 | Output bus should be driven |
| wr_wrap | output | 1 | Write pointer stepped down to zero |
| rd_wrap | output | 1 | Read pointer stepped down to zero |

## Verification
Three pairs of functions can land in one cycle:
- a write and a read at the same address;
- a pointer load and an enable on the same side;
- a wrap event and a flag clear.

The bench forces each pair directly. It reloads both pointers to one address and then raises `wr_en` and `rd_load` together. It asserts `wr_load` with `wr_en`. It pulls a flag clear low on the very step that reaches zero. A long random phase then mixes all inputs. A behavioural model reads its array before applying the write and gives loads and clears priority. Every output is compared against that model on every clock.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam int BANK_W = 3;
endpackage

// File: rtl/seqbuf_ctr.sv
module seqbuf_ctr
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter bit STEP_ON_LOAD = 1'b0
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              load,
    input  logic              adv,
    input  logic              use_clear,
    input  logic [ADDR_W-1:0] reload_val,
    input  dir_e              dir,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] nxt,
    output logic              wrap_evt
);
    logic [ADDR_W-1:0] clear_val;
    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] stepped;
    logic              stepping;

    always_comb begin
        clear_val = (dir == DIR_DOWN) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
        load_val  = use_clear ? clear_val : reload_val;
        base      = load ? load_val : cur;
        stepped   = (dir == DIR_DOWN) ? base - ADDR_W'(1) : base + ADDR_W'(1);
    end

    generate
        if (STEP_ON_LOAD) begin : g_step_after_load
            assign stepping = load | adv;
        end else begin : g_load_only
            assign stepping = ~load & adv;
        end
    endgenerate

    assign nxt      = stepping ? stepped : base;
    assign wrap_evt = stepping & (dir == DIR_DOWN) & (stepped == '0);
endmodule

// File: rtl/seqbuf_ram.sv
module seqbuf_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seqbuf_mem.sv
module seqbuf_mem
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_count_down,
    input  logic              cfg_wr_clear,
    input  logic              cfg_rd_clear,
    input  logic              cfg_oe_async,
    input  logic [BANK_W-1:0] cfg_bank_id,
    input  logic [ADDR_W-1:0] wr_reload_val,
    input  logic [ADDR_W-1:0] rd_reload_val,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              wr_load,
    input  logic              rd_load,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_flag_clr_n,
    input  logic              rd_flag_clr_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              dout_drive,
    output logic              wr_wrap,
    output logic              rd_wrap
);
    localparam int BANK_LSB = ADDR_W - BANK_W;

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [DATA_W-1:0] dout;
        logic              valid;
        logic              hit;
        logic              oe;
        logic              wflag;
        logic              rflag;
    } state_t;

    state_t st_q, st_d;

    dir_e              dir;
    logic [ADDR_W-1:0] w_base, w_nxt, r_base, r_nxt;
    logic              w_evt, r_evt;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic              rd_go;
    logic              oe_act;

    assign dir = dir_e'(cfg_count_down);

    seqbuf_ctr #(.ADDR_W(ADDR_W), .STEP_ON_LOAD(1'b0)) u_wctr (
        .cur        (st_q.wptr),
        .load       (wr_load),
        .adv        (wr_en),
        .use_clear  (cfg_wr_clear),
        .reload_val (wr_reload_val),
        .dir        (dir),
        .base       (w_base),
        .nxt        (w_nxt),
        .wrap_evt   (w_evt)
    );

    seqbuf_ctr #(.ADDR_W(ADDR_W), .STEP_ON_LOAD(1'b1)) u_rctr (
        .cur        (st_q.rptr),
        .load       (rd_load),
        .adv        (rd_en),
        .use_clear  (cfg_rd_clear),
        .reload_val (rd_reload_val),
        .dir        (dir),
        .base       (r_base),
        .nxt        (r_nxt),
        .wrap_evt   (r_evt)
    );

    assign ram_we = wr_en & ~wr_load & (w_base[ADDR_W-1:BANK_LSB] == cfg_bank_id);

    seqbuf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (w_base),
        .wdata (din),
        .raddr (r_base),
        .rdata (ram_rdata)
    );

    assign rd_go = rd_en | rd_load;

    always_comb begin
        st_d       = st_q;
        st_d.wptr  = w_nxt;
        st_d.rptr  = r_nxt;
        st_d.valid = rd_go;
        st_d.oe    = ~oe_n;
        if (rd_go) begin
            st_d.dout = ram_rdata;
            st_d.hit  = (r_base[ADDR_W-1:BANK_LSB] == cfg_bank_id);
        end
        st_d.wflag = wr_flag_clr_n ? (st_q.wflag | w_evt) : 1'b0;
        st_d.rflag = rd_flag_clr_n ? (st_q.rflag | r_evt) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_act     = cfg_oe_async ? ~oe_n : st_q.oe;
    assign dout       = st_q.dout;
    assign dout_valid = st_q.valid;
    assign dout_drive = st_q.hit & oe_act;
    assign wr_wrap    = st_q.wflag;
    assign rd_wrap    = st_q.rflag;

    // Write pointer holds when the write side is idle
    assert_wr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wr_load) |=> $stable(st_q.wptr));

    // Output register holds when no read occurs
    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_load) |=> $stable(dout));

    // Up-count read step adds exactly one
    assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_load && !cfg_count_down) |=> (st_q.rptr == $past(st_q.rptr) + ADDR_W'(1)));

    // Direct output enable blocks drive at once
    assert_oe_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_async && oe_n) |-> !dout_drive);

    // Registered output enable blocks drive after the edge
    assert_oe_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_oe_async && oe_n) |=> (cfg_oe_async || !dout_drive));

    // Up counting never raises a clear flag
    assert_rflag_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_count_down && !rd_wrap && rd_flag_clr_n) |=> !rd_wrap);

    // Clear input wins over any wrap
    assert_wflag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag_clr_n |=> !wr_wrap);
    assert_rflag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_flag_clr_n |=> !rd_wrap);

    // Valid is a one-cycle echo of a read
    assert_valid_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || rd_load) |=> dout_valid);
    assert_valid_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_load) |=> !dout_valid);
endmodule

// File: tb/seqbuf_mem_test.sv
module seqbuf_mem_test;
    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_count_down = 1'b0, cfg_wr_clear = 1'b0, cfg_rd_clear = 1'b0, cfg_oe_async = 1'b0;
    logic [2:0] cfg_bank_id = '0;
    logic [AW-1:0] wr_reload_val = '0, rd_reload_val = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, wr_load = 1'b0, rd_load = 1'b0, oe_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic wr_flag_clr_n = 1'b1, rd_flag_clr_n = 1'b1;
    logic [DW-1:0] dout;
    logic dout_valid, dout_drive, wr_wrap, rd_wrap;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    int m_mem [DEPTH];
    int m_wp = 0, m_rp = 0, m_dout = 0, m_valid = 0, m_hit = 0, m_oe = 0, m_wf = 0, m_rf = 0;

    always #2.5 clk = ~clk;

    seqbuf_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_count_down(cfg_count_down), .cfg_wr_clear(cfg_wr_clear),
        .cfg_rd_clear(cfg_rd_clear), .cfg_oe_async(cfg_oe_async),
        .cfg_bank_id(cfg_bank_id),
        .wr_reload_val(wr_reload_val), .rd_reload_val(rd_reload_val),
        .wr_en(wr_en), .rd_en(rd_en), .wr_load(wr_load), .rd_load(rd_load),
        .oe_n(oe_n), .din(din),
        .wr_flag_clr_n(wr_flag_clr_n), .rd_flag_clr_n(rd_flag_clr_n),
        .dout(dout), .dout_valid(dout_valid), .dout_drive(dout_drive),
        .wr_wrap(wr_wrap), .rd_wrap(rd_wrap)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int drv;
        drv = m_hit & (cfg_oe_async ? int'(!oe_n) : m_oe);
        chk("R2 dout", int'(dout), m_dout);
        chk("R11 dout_valid", int'(dout_valid), m_valid);
        chk("R7 R8 dout_drive", int'(dout_drive), drv);
        chk("R9 R10 wr_wrap", int'(wr_wrap), m_wf);
        chk("R9 R10 rd_wrap", int'(rd_wrap), m_rf);
    endtask

    function automatic int stepv(int a, bit down);
        return down ? (a + DEPTH - 1) % DEPTH : (a + 1) % DEPTH;
    endfunction

    // One clock: model update from current inputs, then compare after the edge
    task automatic tick();
        int wb, rb, wn, rn, wev, rev, wstep, rstep, clr, id;
        bit dn;
        dn  = cfg_count_down;
        id  = int'(cfg_bank_id);
        clr = dn ? DEPTH - 1 : 0;
        wb = wr_load ? (cfg_wr_clear ? clr : int'(wr_reload_val)) : m_wp;
        rb = rd_load ? (cfg_rd_clear ? clr : int'(rd_reload_val)) : m_rp;
        wstep = int'(!wr_load && wr_en);
        rstep = int'(rd_load || rd_en);
        wn = wstep ? stepv(wb, dn) : wb;
        rn = rstep ? stepv(rb, dn) : rb;
        wev = int'(wstep && dn && wn == 0);
        rev = int'(rstep && dn && rn == 0);
        m_valid = rstep;
        if (rstep != 0) begin
            m_dout = m_mem[rb];
            m_hit  = int'((rb >> (AW - 3)) == id);
        end
        if (wstep != 0 && (wb >> (AW - 3)) == id) m_mem[wb] = int'(din);
        m_wp = wn;
        m_rp = rn;
        m_oe = int'(!oe_n);
        m_wf = !wr_flag_clr_n ? 0 : (m_wf | wev);
        m_rf = !rd_flag_clr_n ? 0 : (m_rf | rev);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; wr_load = 0; rd_load = 0;
        wr_flag_clr_n = 1; rd_flag_clr_n = 1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        // R12: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R12 dout", int'(dout), 0);
        chk("R12 dout_valid", int'(dout_valid), 0);
        chk("R12 dout_drive", int'(dout_drive), 0);
        chk("R12 wr_wrap", int'(wr_wrap), 0);
        chk("R12 rd_wrap", int'(rd_wrap), 0);
        rst_n = 1'b1;
        tick();

        // R1 R6: fill every bank, bank ID follows the write pointer
        for (int i = 0; i < DEPTH; i++) begin
            cfg_bank_id = 3'(i >> (AW - 3));
            wr_en = 1; din = DW'(i * 7 + 3);
            tick();
        end
        idle();

        // R2 R3 R5 R8 R11: up-count reads of bank 0 with registered enable
        cfg_bank_id = 0; oe_n = 0; cfg_rd_clear = 1; rd_load = 1;
        tick();
        rd_load = 0; rd_en = 1;
        for (int i = 0; i < 20; i++) tick();
        idle();
        oe_n = 1; tick(); tick();
        oe_n = 0;

        // R4 R5: reload values, load has priority over enable
        cfg_wr_clear = 0; cfg_rd_clear = 0;
        wr_reload_val = 50; rd_reload_val = 50;
        wr_load = 1; wr_en = 1; din = 8'hEE; tick();
        wr_load = 0; din = 8'h5A; rd_load = 1; tick();
        rd_load = 0; rd_en = 1; din = 8'hC3; tick();
        idle();
        // R2: read and write to the same address in one cycle
        wr_reload_val = 60; rd_reload_val = 60; wr_load = 1; tick();
        wr_load = 0; wr_en = 1; din = 8'h99; rd_load = 1; tick();
        idle(); rd_load = 1; tick();
        idle(); tick();

        // R3 R4 R5: down counting from the cleared value, bank 7
        cfg_count_down = 1; cfg_bank_id = 7; cfg_wr_clear = 1; cfg_rd_clear = 1;
        wr_load = 1; tick();
        wr_load = 0; wr_en = 1;
        for (int i = 0; i < 5; i++) begin din = DW'(200 + i); tick(); end
        idle(); rd_load = 1; tick();
        rd_load = 0; rd_en = 1;
        for (int i = 0; i < 6; i++) tick();
        idle();

        // R9 R10: wrap flags set stepping down to zero, clear wins
        cfg_bank_id = 0; cfg_wr_clear = 0; cfg_rd_clear = 0;
        wr_reload_val = 3; wr_load = 1; tick();
        wr_load = 0; wr_en = 1;
        for (int i = 0; i < 4; i++) tick();
        idle(); tick();
        wr_flag_clr_n = 0; tick();
        idle(); wr_reload_val = 1; wr_load = 1; tick();
        wr_load = 0; wr_en = 1; wr_flag_clr_n = 0; tick();
        idle(); tick();
        rd_reload_val = 2; rd_load = 1; tick();
        rd_load = 0; rd_en = 1; tick();
        idle(); tick();
        rd_flag_clr_n = 0; tick();
        idle();
        // R9: stepping up through zero does not set a flag
        cfg_count_down = 0; wr_reload_val = AW'(DEPTH - 1); wr_load = 1; tick();
        wr_load = 0; wr_en = 1; tick(); tick();
        idle(); tick();

        // R7 R8: direct output enable and foreign-bank reads
        cfg_oe_async = 1;
        cfg_rd_clear = 1; rd_load = 1; tick();
        rd_load = 0; rd_en = 1;
        for (int i = 0; i < 8; i++) begin oe_n = i[0]; tick(); end
        cfg_bank_id = 3; tick(); tick();
        idle(); cfg_oe_async = 0; cfg_bank_id = 0;

        // R1..R11 mixed: random stimulus
        for (int i = 0; i < 3000; i++) begin
            wr_en = 1'($urandom_range(0, 1));
            rd_en = 1'($urandom_range(0, 1));
            wr_load = ($urandom_range(0, 15) == 0);
            rd_load = ($urandom_range(0, 15) == 0);
            din = DW'($urandom);
            oe_n = ($urandom_range(0, 3) == 0);
            wr_flag_clr_n = ($urandom_range(0, 19) != 0);
            rd_flag_clr_n = ($urandom_range(0, 19) != 0);
            wr_reload_val = AW'($urandom_range(0, 3));
            rd_reload_val = AW'($urandom_range(0, 3));
            if ($urandom_range(0, 63) == 0) begin
                cfg_count_down = 1'($urandom_range(0, 1));
                cfg_wr_clear   = 1'($urandom_range(0, 1));
                cfg_rd_clear   = 1'($urandom_range(0, 1));
                cfg_oe_async   = 1'($urandom_range(0, 1));
                cfg_bank_id    = 3'($urandom_range(0, 7));
            end
            tick();
        end
        idle(); tick();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule